// File: doc/BRIEF.md
# Sequential LMS Adaptive FIR Engine

This block is an adaptive FIR filter with eight taps. It uses one shift-add multiplier and one adder/subtractor for all of its arithmetic, so it trades throughput for area. Input samples and weights are kept in two circular register rings. The rings rotate one step after each multiply is issued, so each ring's head register always holds the next operand.

Each iteration has two phases.

- **Filter phase:** the new sample and the desired value are taken on a load strobe. Eight products are summed in a 16-bit accumulator to form the output Y. The adder then switches to subtract mode to form the error E.
- **Update phase:** the engine runs eight more multiplies, each of the error by the matching sample. Each product is added to the scaled weight, and the upper byte of the sum is written back into the weight ring.

After the update phase, the sample ring takes one extra step so the next sample overwrites the oldest one. A one-cycle `done` pulse then marks the end of the iteration.

Every multiply is launched on an even cycle counted from reset. A launch that would fall on an odd cycle is held back by one cycle.

Top module: `lms_engine`

## Requirements
- R1: After the reset or after a cycle with `restart` high, `y_out`, `err_out` and `done` are zero and every stored sample and weight is zero. As a result, the first iteration that follows gives Y = 0 and E = D.
- R2: A load strobe is accepted only while the engine is idle: after reset, after restart, or once `done` has pulsed. Strobes and input values presented while an iteration runs have no effect on any result.
- R3: Y is the sum, modulo 2^16, of eight 16-bit signed products of 8-bit two's complement operands. The weight in ring slot k, where k = 0 is the first slot visited, multiplies the sample loaded (8 − k) mod 8 iterations earlier. For k = 0 that is the sample just loaded.
- R4: E is bits [15:8] of ({D, 8'h00} − Y) modulo 2^16, read as a two's complement byte.
- R5: Every weight w in slot k becomes bits [15:8] of ({w, 8'h00} + x·E) modulo 2^16, where x is the sample paired with slot k as in R3. The new weights take effect in the next iteration.
- R6: The sample history is a sliding window of the eight most recent samples. A new sample replaces the oldest one, and older samples no longer contribute.
- R7: `done` is high for exactly one cycle per completed iteration. `y_out` and `err_out` already hold that iteration's results while `done` is high.
- R8: A multiply starts only on a cycle whose count since reset is even. Results do not depend on the parity of the cycle in which the sample is loaded.
- R9: Each iteration issues exactly eight filter multiplies and eight update multiplies. A multiply never starts while another is still in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Synchronous clear of all stored state, returns to idle |
| load | input | 1 | Strobe: take `sample_in` and `desired_in` and begin an iteration |
| sample_in | input | 8 | New input sample, two's complement |
| desired_in | input | 8 | Desired response D, two's complement |
| y_out | output | 16 | Filter output Y of the last iteration |
| err_out | output | 8 | Error E of the last iteration |
| done | output | 1 | One-cycle pulse at the end of an iteration |

## Verification
The bench runs more than sixty iterations against an arithmetic model of the rings and truncation. The inputs include counting sequences, the extreme values +127 and −128, and a pseudo-random series. These catch a reversed ring direction or a missing final sample rotation, because either one pairs weights with the wrong sample ages and Y drifts away from the model after a few iterations.

Idle gaps of zero to three cycles move the load through both clock parities. A design that lost or repeated a product when a multiply launch was delayed would return a wrong Y only for one of the two parities.

Some iterations toggle `load` with different data while the engine is busy; a design that took those strobes would corrupt its history. A restart in the middle of an iteration must return everything to zero, so the next error must equal D exactly.

// File: rtl/lms_pkg.sv
// Shared types of the LMS engine: controller states and the control word
// the sequencer hands to the datapath. Assumes nothing about widths.
package lms_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_XW_ISSUE,
        ST_XW_WAIT,
        ST_XW_ACC,
        ST_SUB,
        ST_ELATCH,
        ST_UP_ISSUE,
        ST_UP_WAIT,
        ST_UP_ADD,
        ST_UP_WB,
        ST_XROT,
        ST_FINAL
    } lms_state_e;

    typedef struct packed {
        logic clr_all;     // wipe every register of the engine
        logic x_wr;        // write new sample into sample ring head
        logic x_rot;       // advance sample ring
        logic w_wr;        // write updated weight while rotating
        logic w_rot;       // advance weight ring
        logic mul_start;   // launch a multiply
        logic mul_use_err; // second multiplier operand is E, not weight
        logic acc_clr;     // zero the accumulator
        logic acc_add;     // accumulator += product
        logic acc_sub;     // accumulator = {D,0} - accumulator
        logic acc_ldw;     // accumulator = {weight,0}
        logic d_lat;       // capture desired value
        logic y_lat;       // capture filter output
        logic e_lat;       // capture error byte
    } lms_ctl_t;

endpackage

// File: rtl/lms_ring_stack.sv
// Circular register ring of DEPTH entries; entry 0 is the head seen by the
// datapath. A rotate moves every entry one place toward the head and the
// old head to the tail; a write during a rotate replaces the value that
// moves to the tail, a write alone replaces the head.
// Assumes DEPTH >= 2.
module lms_ring_stack #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          rot,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head
);

    logic [DW-1:0] slot [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        logic [DW-1:0] val_q;
        logic [DW-1:0] from_rot;
        logic [DW-1:0] from_wr;

        if (gi == DEPTH - 1) begin : g_tail
            assign from_rot = wr ? wdata : slot[0];
        end else begin : g_body
            assign from_rot = slot[gi + 1];
        end

        if (gi == 0) begin : g_head
            assign from_wr = wdata;
        end else begin : g_rest
            assign from_wr = val_q;
        end

        // Hold, shift toward head, or take a new value for this entry.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                val_q <= '0;
            end else if (rot) begin
                val_q <= from_rot;
            end else if (wr) begin
                val_q <= from_wr;
            end
        end

        assign slot[gi] = val_q;
    end

    assign head = slot[0];

endmodule

// File: rtl/lms_shift_mult.sv
// Signed DW x DW multiplier, one multiplier bit per cycle. A start latches
// the operands; DW cycles later fin rises and prod holds the 2*DW-bit
// two's complement product until the next start. The top bit carries
// negative weight, so the last step subtracts.
// Assumes start is not raised while a multiply is in progress.
module lms_shift_mult #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            start,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [2*DW-1:0] prod,
    output logic            fin
);

    localparam int PW = 2 * DW;
    localparam int SW = $clog2(DW + 1);

    logic [PW-1:0] mcand_q;
    logic [PW-1:0] acc_q;
    logic [DW-1:0] mplr_q;
    logic [SW-1:0] step_q;
    logic          busy_q;
    logic          fin_q;
    logic          last_step;
    logic [PW-1:0] addend;

    assign last_step = (step_q == SW'(DW - 1));
    assign addend    = mplr_q[0] ? mcand_q : '0;

    // Operand capture and one shift-add step per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mcand_q <= '0;
            acc_q   <= '0;
            mplr_q  <= '0;
            step_q  <= '0;
            busy_q  <= 1'b0;
            fin_q   <= 1'b0;
        end else if (start) begin
            mcand_q <= {{DW{a[DW-1]}}, a};
            mplr_q  <= b;
            acc_q   <= '0;
            step_q  <= '0;
            busy_q  <= 1'b1;
            fin_q   <= 1'b0;
        end else if (busy_q) begin
            acc_q   <= last_step ? (acc_q - addend) : (acc_q + addend);
            mcand_q <= mcand_q << 1;
            mplr_q  <= mplr_q >> 1;
            step_q  <= step_q + 1'b1;
            if (last_step) begin
                busy_q <= 1'b0;
                fin_q  <= 1'b1;
            end
        end
    end

    assign prod = acc_q;
    assign fin  = fin_q;

    // R9
    mult_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);

endmodule

// File: rtl/lms_ctrl.sv
// Sequencer of the LMS engine. It walks the filter phase (NTAPS multiply/
// accumulate rounds, subtract, error latch), then the update phase (NTAPS
// rounds of load weight, multiply by error, add, write back), then one
// extra sample-ring step and a final wait that raises done.
// Assumes phase_even alternates every cycle and mul_fin stays high from
// multiply completion until the next start.
module lms_ctrl
    import lms_pkg::*;
#(
    parameter int NTAPS = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart,
    input  logic     load,
    input  logic     phase_even,
    input  logic     mul_fin,
    output lms_ctl_t ctl,
    output logic     done
);

    localparam int TW = (NTAPS > 1) ? $clog2(NTAPS) : 1;

    lms_state_e    state_q, state_d;
    logic [TW-1:0] tap_q, tap_d;
    logic          done_q;
    logic          last_tap;

    assign last_tap = (tap_q == TW'(NTAPS - 1));

    // Next state, tap count and control word for the current state.
    always_comb begin
        ctl     = '0;
        state_d = state_q;
        tap_d   = tap_q;
        case (state_q)
            ST_IDLE: begin
                if (load) begin
                    ctl.x_wr    = 1'b1;
                    ctl.d_lat   = 1'b1;
                    ctl.acc_clr = 1'b1;
                    tap_d       = '0;
                    state_d     = ST_XW_ISSUE;
                end
            end
            ST_XW_ISSUE: begin
                if (phase_even) begin
                    ctl.mul_start = 1'b1;
                    ctl.x_rot     = 1'b1;
                    ctl.w_rot     = 1'b1;
                    state_d       = ST_XW_WAIT;
                end
            end
            ST_XW_WAIT: begin
                if (mul_fin) begin
                    state_d = ST_XW_ACC;
                end
            end
            ST_XW_ACC: begin
                ctl.acc_add = 1'b1;
                if (last_tap) begin
                    tap_d   = '0;
                    state_d = ST_SUB;
                end else begin
                    tap_d   = tap_q + 1'b1;
                    state_d = ST_XW_ISSUE;
                end
            end
            ST_SUB: begin
                ctl.acc_sub = 1'b1;
                ctl.y_lat   = 1'b1;
                state_d     = ST_ELATCH;
            end
            ST_ELATCH: begin
                ctl.e_lat = 1'b1;
                state_d   = ST_UP_ISSUE;
            end
            ST_UP_ISSUE: begin
                if (phase_even) begin
                    ctl.mul_start   = 1'b1;
                    ctl.mul_use_err = 1'b1;
                    ctl.acc_ldw     = 1'b1;
                    state_d         = ST_UP_WAIT;
                end
            end
            ST_UP_WAIT: begin
                if (mul_fin) begin
                    state_d = ST_UP_ADD;
                end
            end
            ST_UP_ADD: begin
                ctl.acc_add = 1'b1;
                state_d     = ST_UP_WB;
            end
            ST_UP_WB: begin
                ctl.w_wr  = 1'b1;
                ctl.w_rot = 1'b1;
                ctl.x_rot = 1'b1;
                if (last_tap) begin
                    tap_d   = '0;
                    state_d = ST_XROT;
                end else begin
                    tap_d   = tap_q + 1'b1;
                    state_d = ST_UP_ISSUE;
                end
            end
            ST_XROT: begin
                ctl.x_rot = 1'b1;
                state_d   = ST_FINAL;
            end
            ST_FINAL: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        if (restart) begin
            ctl         = '0;
            ctl.clr_all = 1'b1;
            state_d     = ST_IDLE;
            tap_d       = '0;
        end
    end

    // State, tap count and done pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tap_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            tap_q   <= tap_d;
            done_q  <= !restart && (state_q == ST_FINAL);
        end
    end

    assign done = done_q;

    // R7
    done_in_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state_q == ST_IDLE));

endmodule

// File: rtl/lms_addsub.sv
// The engine's single adder: sum = a + b, or a - b when sub is high.
// Purely combinational; widths wrap modulo 2^W.
module lms_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum
);

    // Add or subtract the two operands.
    always_comb begin
        sum = sub ? (a - b) : (a + b);
    end

endmodule

// File: rtl/lms_engine.sv
// Top of the sequential LMS adaptive FIR engine. Holds the accumulator and
// the D, Y and E registers, routes operands from the two rings into the
// shared multiplier and adder, and keeps the cycle-parity flag that the
// sequencer uses to align multiply launches.
// Assumes load is only meaningful while idle; strobes at other times are
// dropped by the sequencer.
module lms_engine #(
    parameter int DW    = 8,
    parameter int NTAPS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            load,
    input  logic [DW-1:0]   sample_in,
    input  logic [DW-1:0]   desired_in,
    output logic [2*DW-1:0] y_out,
    output logic [DW-1:0]   err_out,
    output logic            done
);

    import lms_pkg::*;

    localparam int PW  = 2 * DW;
    localparam int SCW = $clog2(2 * NTAPS + 1);

    lms_ctl_t      ctl;
    logic          phase_odd_q;
    logic [DW-1:0] x_head;
    logic [DW-1:0] w_head;
    logic [PW-1:0] prod;
    logic          mul_fin;
    logic [DW-1:0] mul_b;
    logic [PW-1:0] add_a;
    logic [PW-1:0] add_b;
    logic [PW-1:0] add_sum;
    logic [PW-1:0] acc_q;
    logic [DW-1:0] d_q;
    logic [PW-1:0] y_q;
    logic [DW-1:0] e_q;

    // Cycle parity since reset, used to keep multiply launches on even cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_odd_q <= 1'b0;
        end else begin
            phase_odd_q <= !phase_odd_q;
        end
    end

    lms_ctrl #(.NTAPS(NTAPS)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .load       (load),
        .phase_even (!phase_odd_q),
        .mul_fin    (mul_fin),
        .ctl        (ctl),
        .done       (done)
    );

    lms_ring_stack #(.DW(DW), .DEPTH(NTAPS)) i_xring (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctl.clr_all),
        .rot   (ctl.x_rot),
        .wr    (ctl.x_wr),
        .wdata (sample_in),
        .head  (x_head)
    );

    lms_ring_stack #(.DW(DW), .DEPTH(NTAPS)) i_wring (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctl.clr_all),
        .rot   (ctl.w_rot),
        .wr    (ctl.w_wr),
        .wdata (acc_q[PW-1:DW]),
        .head  (w_head)
    );

    assign mul_b = ctl.mul_use_err ? e_q : w_head;

    lms_shift_mult #(.DW(DW)) i_mult (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctl.clr_all),
        .start (ctl.mul_start),
        .a     (x_head),
        .b     (mul_b),
        .prod  (prod),
        .fin   (mul_fin)
    );

    assign add_a = ctl.acc_sub ? {d_q, {DW{1'b0}}} : acc_q;
    assign add_b = ctl.acc_sub ? acc_q : prod;

    lms_addsub #(.W(PW)) i_adder (
        .a   (add_a),
        .b   (add_b),
        .sub (ctl.acc_sub),
        .sum (add_sum)
    );

    // Accumulator: clear, load scaled weight, or take the adder result.
    always_ff @(posedge clk) begin
        if (!rst_n || ctl.clr_all || ctl.acc_clr) begin
            acc_q <= '0;
        end else if (ctl.acc_ldw) begin
            acc_q <= {w_head, {DW{1'b0}}};
        end else if (ctl.acc_add || ctl.acc_sub) begin
            acc_q <= add_sum;
        end
    end

    // Desired value, filter output and error byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n || ctl.clr_all) begin
            d_q <= '0;
            y_q <= '0;
            e_q <= '0;
        end else begin
            if (ctl.d_lat) begin
                d_q <= desired_in;
            end
            if (ctl.y_lat) begin
                y_q <= acc_q;
            end
            if (ctl.e_lat) begin
                e_q <= acc_q[PW-1:DW];
            end
        end
    end

    assign y_out   = y_q;
    assign err_out = e_q;

    // Multiply launches since the last accepted sample (checker support).
    logic [SCW-1:0] starts_q;
    always_ff @(posedge clk) begin
        if (!rst_n || ctl.clr_all || ctl.x_wr) begin
            starts_q <= '0;
        end else if (ctl.mul_start) begin
            starts_q <= starts_q + 1'b1;
        end
    end

    // R8
    mult_even_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mul_start |-> !phase_odd_q);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (y_out == '0 && err_out == '0 && !done));

    // R9
    mult_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (starts_q == SCW'(2 * NTAPS)));

endmodule

// File: tb/test_lms_engine.sv
module test_lms_engine;

    localparam int DW = 8;
    localparam int NT = 8;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          restart = 1'b0;
    logic          load = 1'b0;
    logic [DW-1:0] sample_in = '0;
    logic [DW-1:0] desired_in = '0;
    logic [PW-1:0] y_out;
    logic [DW-1:0] err_out;
    logic          done;

    int n_chk = 0;
    int n_bad = 0;

    logic [DW-1:0] hist [NT];
    logic [DW-1:0] wt   [NT];
    logic [PW-1:0] exp_y;
    logic [DW-1:0] exp_e;

    always #10 clk = ~clk;

    lms_engine #(.DW(DW), .NTAPS(NT)) i_lms_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .load       (load),
        .sample_in  (sample_in),
        .desired_in (desired_in),
        .y_out      (y_out),
        .err_out    (err_out),
        .done       (done)
    );

    function automatic logic [PW-1:0] mul16(input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic signed [PW-1:0] sa;
        logic signed [PW-1:0] sb;
        sa = PW'($signed(a));
        sb = PW'($signed(b));
        return PW'(sa * sb);
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < NT; k++) begin
            hist[k] = '0;
            wt[k]   = '0;
        end
    endtask

    // Reference iteration computed from R3..R6.
    task automatic model_step(input logic [DW-1:0] x, input logic [DW-1:0] d);
        logic [PW-1:0] acc;
        logic [PW-1:0] diff;
        logic [PW-1:0] s;
        for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        acc = '0;
        for (int r = 0; r < NT; r++) acc = acc + mul16(wt[r], hist[(NT - r) % NT]);
        exp_y = acc;
        diff  = {d, 8'h00} - acc;
        exp_e = diff[PW-1:DW];
        for (int r = 0; r < NT; r++) begin
            s     = {wt[r], 8'h00} + mul16(hist[(NT - r) % NT], exp_e);
            wt[r] = s[PW-1:DW];
        end
    endtask

    task automatic run_iter(input logic [DW-1:0] x, input logic [DW-1:0] d,
                            input int gap, input bit junk, input string tag);
        int cnt;
        repeat (gap) @(negedge clk);
        sample_in  = x;
        desired_in = d;
        load       = 1'b1;
        @(negedge clk);
        load = 1'b0;
        model_step(x, d);
        cnt = 0;
        while (!done && cnt < 4000) begin
            if (junk && cnt < 40) begin
                load       = 1'b1;
                sample_in  = ~x;
                desired_in = x ^ 8'h5a;
            end else begin
                load = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        load = 1'b0;
        chk({tag, " R7 done reached"}, 32'(done), 32'd1);
        chk({tag, " y_out"}, 32'(y_out), 32'(exp_y));
        chk({tag, " R4 err_out"}, 32'(err_out), 32'(exp_e));
        @(negedge clk);
        chk("R7 done one cycle", 32'(done), 32'd0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 reset y_out", 32'(y_out), 32'd0);
        chk("R1 reset err_out", 32'(err_out), 32'd0);
        chk("R1 reset done", 32'(done), 32'd0);

        // R1 first iteration from cleared state: Y = 0, E = D
        run_iter(8'd100, 8'd100, 0, 1'b0, "R1 R3");

        // R3 R5 R6 counting sequences, gaps sweep parity for R8
        for (int i = 0; i < 14; i++) begin
            run_iter(8'((i * 37 + 11) & 8'hff), 8'((i * 53 + 7) & 8'hff), i % 4, 1'b0, "R3 R5 R6 R8");
        end

        // R3 R4 extremes of the two's complement range
        for (int i = 0; i < 8; i++) begin
            run_iter((i % 2 == 0) ? 8'h7f : 8'h80, (i % 3 == 0) ? 8'h80 : 8'h7f, 1, 1'b0, "R3 R4");
        end

        // R2 loads toggled while the engine is busy
        for (int i = 0; i < 6; i++) begin
            run_iter(8'(i * 29 + 3), 8'(200 - i * 17), 2, 1'b1, "R2");
        end

        // R8 pseudo-random series with varying load parity
        lfsr = 16'hace1;
        for (int i = 0; i < 24; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            run_iter(lfsr[7:0], lfsr[15:8], (i * 3) % 4, 1'b0, "R8 R3 R5");
        end

        // R1 restart in the middle of an iteration
        @(negedge clk);
        sample_in  = 8'h44;
        desired_in = 8'h22;
        load       = 1'b1;
        @(negedge clk);
        load = 1'b0;
        repeat (50) @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        chk("R1 restart y_out", 32'(y_out), 32'd0);
        chk("R1 restart err_out", 32'(err_out), 32'd0);
        chk("R1 restart done", 32'(done), 32'd0);
        model_clear();
        run_iter(8'd5, 8'd200, 1, 1'b0, "R1 R3");

        // R9 R6 impulse: one sample walks through every tap then leaves
        run_iter(8'd90, 8'd120, 0, 1'b0, "R9 R6");
        for (int i = 0; i < 10; i++) begin
            run_iter(8'd0, 8'(i * 11), i % 2, 1'b0, "R9 R6");
        end

        summary();
        $finish;
    end

endmodule